// File: doc/BRIEF.md
# Polyphase Phase Sequencer

This block selects which polyphase of a decimating FIR filter is applied to each incoming sample. A phase accumulator modulo 16 advances by a programmable step on every valid input sample. The step size sets the decimation rate: a step of 1 visits all 16 phases before an output is due, and a step of 16 makes every sample produce an output. When the accumulator wraps, the block raises a one-cycle dump strobe, telling the downstream multiply-accumulate path to emit and clear its sums.

For each of the 10 taps the block provides a coefficient address and the coefficient stored at that address. Tap k at phase p uses address 16k+p, so prototype coefficient h[16k+p] belongs to polyphase p. A small register file on a simple address/write/read bus holds the phase step, a right-shift scaling amount that is exported to the datapath, and the 160-word coefficient memory. All of these can be rewritten while samples are flowing. A step change never resets the accumulator, so the phase sequence stays continuous.

Top module: `polyphase_seq`

## Requirements
- R1: After reset, phase_idx is 0, dump is low, scale_shift is 0, and the step register reads back as 1.
- R2: On a cycle with in_valid high, phase_idx becomes (phase_idx + step) mod 16 at the next edge. Without in_valid it holds.
- R3: dump is high exactly in a cycle where in_valid is high and phase_idx + step >= 16. It is therefore aligned with the phase index of the sample that completes the wrap.
- R4: Steps 16, 8, 4, 2 and 1 give decimation by 1, 2, 4, 8 and 16. Over 32 consecutive samples, dump is seen 2*step times.
- R5: A bus write to address 0 whose data is 1, 2, 4, 8 or 16 loads the step. Any other data is ignored, and the step keeps its old value. No step write alters the phase.
- R6: If a step write and a valid sample share a cycle, that sample uses the old step and the next sample uses the new one.
- R7: A write to address 1 stores the low 5 data bits as the scaling shift, which drives scale_shift from the next cycle.
- R8: A write to address 0x100+i, for i from 0 to 159, stores the low 16 data bits as coefficient i. For tap k, coef_addr[8k+7:8k] equals 16k + phase_idx, and tap_coef[16k+15:16k] equals the coefficient stored at that address.
- R9: A read strobe at address 0, 1 or 0x100 to 0x19F returns the stored value on bus_rdata one cycle later. Any other address returns 0. bus_rdata holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new input sample is present this cycle |
| bus_addr | input | 9 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, registered |
| phase_idx | output | 4 | Polyphase of the current sample |
| dump | output | 1 | Output due with the current sample |
| scale_shift | output | 5 | Right-shift scaling amount for the datapath |
| coef_addr | output | 80 | Per-tap coefficient address, 8 bits per tap |
| tap_coef | output | 160 | Per-tap coefficient value, 16 bits per tap |

## Verification
The risky coincidence is a step-register write in the same clock cycle as a valid sample. The phase update and the dump decision must then use the old step, and the new step must take effect only from the next sample. The bench provokes this by driving in_valid and a step write on the same edge, both with a legal new value and with an illegal one. It checks phase_idx and dump for that sample and the next one against an arithmetic model that changes its step only after the shared cycle.

// File: rtl/polyphase_seq.sv
module polyphase_seq #(
  parameter int PHASES    = 16,
  parameter int TAPS      = 10,
  parameter int CW        = 16,
  parameter int AW        = 9,
  parameter int DW        = 16,
  parameter int SHW       = 5,
  parameter int COEF_BASE = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_rd,
  output logic [DW-1:0]        bus_rdata,
  output logic [$clog2(PHASES)-1:0] phase_idx,
  output logic                 dump,
  output logic [SHW-1:0]       scale_shift,
  output logic [TAPS*$clog2(PHASES*TAPS)-1:0] coef_addr,
  output logic [TAPS*CW-1:0]   tap_coef
);
  localparam int PW    = $clog2(PHASES);
  localparam int SW    = PW + 1;
  localparam int NCOEF = PHASES * TAPS;
  localparam int CAW   = $clog2(NCOEF);

  logic [PW-1:0]  acc;
  logic [SW-1:0]  step_q;
  logic [SHW-1:0] shift_q;
  logic [CW-1:0]  mem [NCOEF];

  wire [SW-1:0] sum = SW'(acc) + step_q;

  assign phase_idx   = acc;
  assign dump        = in_valid & sum[PW];
  assign scale_shift = shift_q;

  wire sel_step  = bus_addr == AW'(0);
  wire sel_shift = bus_addr == AW'(1);
  wire sel_coef  = (bus_addr >= AW'(COEF_BASE)) && (bus_addr < AW'(COEF_BASE + NCOEF));
  wire [CAW-1:0] widx = CAW'(bus_addr - AW'(COEF_BASE));
  wire step_ok = (bus_wdata != '0) && (bus_wdata <= DW'(PHASES)) &&
                 ((bus_wdata & (bus_wdata - DW'(1))) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      step_q  <= SW'(1);
      shift_q <= '0;
    end else begin
      if (in_valid) acc <= sum[PW-1:0];
      if (bus_wr && sel_step && step_ok) step_q <= bus_wdata[SW-1:0];
      if (bus_wr && sel_shift) shift_q <= bus_wdata[SHW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && sel_coef) mem[widx] <= bus_wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          bus_rdata <= '0;
    else if (bus_rd) begin
      if (sel_step)       bus_rdata <= DW'(step_q);
      else if (sel_shift) bus_rdata <= DW'(shift_q);
      else if (sel_coef)  bus_rdata <= DW'(mem[widx]);
      else                bus_rdata <= '0;
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [CAW-1:0] BASE = CAW'(k * PHASES);
    wire [CAW-1:0] a = BASE + CAW'(acc);
    assign coef_addr[k*CAW +: CAW] = a;
    assign tap_coef[k*CW +: CW]    = mem[a];
  end

  p_dump_needs_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dump |-> in_valid);
  p_no_dump_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dump) |=> (phase_idx > $past(phase_idx)));
  p_dump_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (phase_idx <= $past(phase_idx)));
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_idx));
  p_step_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(step_q) == 1) && (step_q <= SW'(PHASES)));
  p_step_write_keeps_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_step && !in_valid) |=> $stable(phase_idx));
endmodule

// File: tb/tb_polyphase_seq.sv
`timescale 1ns/1ps
module tb_polyphase_seq;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [8:0]   bus_addr = '0;
  logic         bus_wr = 0;
  logic [15:0]  bus_wdata = '0;
  logic         bus_rd = 0;
  logic [15:0]  bus_rdata;
  logic [3:0]   phase_idx;
  logic         dump;
  logic [4:0]   scale_shift;
  logic [79:0]  coef_addr;
  logic [159:0] tap_coef;

  polyphase_seq dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .phase_idx(phase_idx), .dump(dump), .scale_shift(scale_shift),
    .coef_addr(coef_addr), .tap_coef(tap_coef));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, mstep = 1, macc = 0, dumps = 0;
  int coefm [160];
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); in_valid = 0; bus_addr = 9'(a); bus_wdata = 16'(d); bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); in_valid = 0; bus_addr = 9'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0; #1 d = int'(bus_rdata);
  endtask

  function automatic bit legal(int v);
    return v == 1 || v == 2 || v == 4 || v == 8 || v == 16;
  endfunction

  task automatic check_taps();
    for (int k = 0; k < 10; k++) begin
      chk("R8 coef_addr", int'(coef_addr[k*8 +: 8]), k*16 + macc);
      chk("R8 tap_coef", int'(tap_coef[k*16 +: 16]), coefm[k*16 + macc]);
    end
  endtask

  // one valid sample, optionally with a step write in the same cycle (R6)
  task automatic sample(bit with_wr, int wv);
    @(negedge clk); in_valid = 1;
    if (with_wr) begin bus_addr = 9'd0; bus_wdata = 16'(wv); bus_wr = 1; end
    #2;
    chk("R2 phase_idx", int'(phase_idx), macc);
    chk("R3 dump", int'(dump), int'(macc + mstep >= 16));
    check_taps();
    if (dump) dumps++;
    @(posedge clk); #1 in_valid = 0; bus_wr = 0;
    macc = (macc + mstep) % 16;
    if (with_wr && legal(wv)) mstep = wv;
  endtask

  int v;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R1 phase", int'(phase_idx), 0);
    chk("R1 dump", int'(dump), 0);
    chk("R1 shift", int'(scale_shift), 0);
    rd(0, v); chk("R1 step readback", v, 1);

    for (int i = 0; i < 160; i++) begin coefm[i] = (i*37 + 5) & 16'hFFFF; wr(256 + i, coefm[i]); end
    for (int i = 0; i < 160; i++) begin rd(256 + i, v); chk("R9 coef readback", v, coefm[i]); end

    // R4: every decimation rate, 32 samples each
    foreach (coefm[j]) if (j < 5) begin
      int s = 16 >> j;
      wr(0, s); mstep = s;
      rd(0, v); chk("R5 step readback", v, s);
      dumps = 0;
      for (int n = 0; n < 32; n++) sample(0, 0);
      chk("R4 dump count", dumps, 2*s);
    end

    // R2: idle cycles hold phase, no dump
    wr(0, 4); mstep = 4;
    sample(0, 0);
    repeat (5) begin @(negedge clk); #2; chk("R2 idle hold", int'(phase_idx), macc); chk("R3 idle dump", int'(dump), 0); end

    // R5: illegal steps ignored, phase kept
    foreach (coefm[j]) if (j < 6) begin
      int bad[6] = '{0, 3, 17, 32, 6, 16'hFFFF};
      wr(0, bad[j]);
      rd(0, v); chk("R5 illegal step ignored", v, mstep);
      #1 chk("R5 phase kept on write", int'(phase_idx), macc);
    end
    wr(0, 2); mstep = 2;
    #1 chk("R5 phase kept on legal write", int'(phase_idx), macc);
    for (int n = 0; n < 10; n++) sample(0, 0);

    // R6: step write coinciding with a sample
    wr(0, 1); mstep = 1;
    for (int n = 0; n < 3; n++) sample(0, 0);
    sample(1, 8);
    for (int n = 0; n < 6; n++) sample(0, 0);
    sample(1, 5);
    for (int n = 0; n < 4; n++) sample(0, 0);
    sample(1, 16);
    for (int n = 0; n < 3; n++) sample(0, 0);
    rd(0, v); chk("R6 step after shared cycle", v, 16);

    // R7: scaling shift
    wr(1, 3);  #1 chk("R7 scale_shift", int'(scale_shift), 3);
    rd(1, v); chk("R7 shift readback", v, 3);
    wr(1, 16'h0FFF); #1 chk("R7 shift truncated", int'(scale_shift), 31);
    rd(1, v); chk("R9 shift readback", v, 31);

    // R9: unmapped reads and hold
    rd(2, v);   chk("R9 unmapped 2", v, 0);
    rd(416, v); chk("R9 unmapped 0x1A0", v, 0);
    rd(255, v); chk("R9 unmapped 0xFF", v, 0);
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", int'(bus_rdata), 0);

    // R8: runtime coefficient rewrite, all phases
    for (int i = 0; i < 160; i += 7) begin coefm[i] = 16'hA000 + i; wr(256 + i, coefm[i]); end
    wr(0, 1); mstep = 1;
    for (int n = 0; n < 16; n++) sample(0, 0);
    wr(416, 16'h1234);
    rd(0, v); chk("R9 out-of-range write ignored", v, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule